// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-facing protocol engine of a 32 KiB serial EEPROM. The
two-wire clock and data lines are oversampled by the system clock. Each line
goes through a synchroniser and a small majority filter, and the filtered lines
are then watched for START and STOP conditions and for clock edges. The engine
checks the select byte against its three strap pins and takes a 16-bit memory
address, high byte first. It then either passes written bytes to an external
page buffer or streams bytes out of an external read port. It pulls the data
line low through an open-drain enable and never drives it high.

The address pointer survives from one transaction to the next. A read that starts
straight after a select byte continues from one past the last byte touched. To
read from an arbitrary location, the host sends a write select and two address
bytes, then issues a repeated START and a read select. When a STOP follows
accepted write data, the engine asks the array to commit the staged page. While
the array reports that it is busy, the engine refuses its select byte, so a host
can poll until the write has finished. A write-protect input is latched once per
write and can reject the whole write.

Top module: `eeprom_serial_slave`

## Requirements
- R1: A START (data falls while clock is high) in any state makes the engine expect a select byte, and a STOP (data rises while clock is high) returns it to idle. Both release the data line. A STOP that follows only address bytes commits nothing, and the pointer keeps the loaded address.
- R2: The select byte is sent MSB first and has the form 1010, then the pins A2 A1 A0, then the direction bit (1 read, 0 write). A byte of any other form is not acknowledged.
- R3: The engine acknowledges by pulling data low during the ninth clock of a matching select byte, of both address bytes and of every accepted write byte.
- R4: The address is sent high byte first. Bit 15 of the 16-bit address is ignored, so the 15 remaining bits select one of 32768 bytes.
- R5: Each written byte goes to the buffer at page base plus offset, where a page is 64 bytes and the offset is address bits 5:0. The offset wraps inside the page, and later bytes overwrite earlier ones. A STOP after accepted write data pulses commit for one cycle with page number address bits 14:6.
- R6: While the array reports busy, the select byte is not acknowledged.
- R7: The write-protect input is latched on the clock falling edge that ends the acknowledge of the low address byte. If it is high, the first data byte is not acknowledged, nothing reaches the buffer and no commit follows.
- R8: A read select returns the byte at the pointer, which is one past the last byte accessed. After address 0x7FFF the pointer moves to 0x0000.
- R9: A read keeps streaming consecutive bytes while the host acknowledges each one. After a host non-acknowledge the engine leaves the data line released.
- R10: A write select and two address bytes, followed by a repeated START and a read select, return data starting at that address without writing anything.
- R11: The engine's data-line drive changes only while the clock is low. It samples incoming bits on clock rising edges.
- R12: A data-line pulse only one system clock long is rejected by the majority filter and is never taken as a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line as seen on the wire |
| dev_sel | input | 3 | Strap pins compared with select bits 3:1 |
| wp | input | 1 | Write protect, high rejects writes |
| wr_busy | input | 1 | Array is performing an internal write |
| rd_data | input | 8 | Byte at rd_addr, one cycle of latency |
| sda_oe | output | 1 | High pulls the data line low |
| rd_addr | output | 15 | Current address pointer for the read port |
| pbuf_we | output | 1 | One-cycle strobe that stages a byte |
| pbuf_addr | output | 15 | Full byte address of the staged byte |
| pbuf_data | output | 8 | Staged byte value |
| commit | output | 1 | One-cycle request to program the staged page |
| commit_page | output | 9 | Page number to program |

## Verification
The hardest situation to reach is a single-cycle spike on the data line while
the clock is high, part way through an address byte. Unfiltered, it would look
like a START and silently restart the transaction. The bench produces it by
driving the first bit of the high address byte by hand and dropping data for
exactly one system clock in the middle of the high phase. It then shows the
spike was ignored in two ways: both address bytes are still acknowledged, and
the repeated-START read that follows returns the byte written earlier at that
address. The page-wrap write and the pointer roll-over from 0x7FFF to 0 are
reached by choosing start addresses right at those edges.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_RLOAD
    } eng_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } cond_t;

    localparam logic [3:0] SEL_TAG = 4'b1010;

    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

    function automatic logic sel_hit(input logic [7:0] b, input logic [2:0] pins);
        return (b[7:4] == SEL_TAG) && (b[3:1] == pins);
    endfunction

endpackage

// File: rtl/eep_line_filter.sv
module eep_line_filter
    import eep_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_out
);

    logic [SYNC_N-1:0] sync_q;
    logic [2:0]        win_q;

    // lines idle high, so everything resets to one
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            win_q    <= '1;
            line_out <= 1'b1;
        end else begin
            sync_q   <= {sync_q[SYNC_N-2:0], line_in};
            win_q    <= {win_q[1:0], sync_q[SYNC_N-1]};
            line_out <= maj3(win_q);
        end
    end

endmodule

// File: rtl/eep_cond_detect.sv
module eep_cond_detect
    import eep_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  bus_t  bus_f,
    output cond_t cond
);

    bus_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= bus_f;
    end

    always_comb begin
        cond.rise  = bus_f.scl & ~prev_q.scl;
        cond.fall  = ~bus_f.scl & prev_q.scl;
        cond.start = bus_f.scl & prev_q.scl & prev_q.sda & ~bus_f.sda;
        cond.stop  = bus_f.scl & prev_q.scl & ~prev_q.sda & bus_f.sda;
    end

endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6,
    parameter int SYNC_N = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scl_in,
    input  logic                     sda_in,
    input  logic [2:0]               dev_sel,
    input  logic                     wp,
    input  logic                     wr_busy,
    input  logic [7:0]               rd_data,
    output logic                     sda_oe,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     pbuf_we,
    output logic [ADDR_W-1:0]        pbuf_addr,
    output logic [7:0]               pbuf_data,
    output logic                     commit,
    output logic [ADDR_W-PAGE_W-1:0] commit_page
);

    localparam int HI_W    = ADDR_W - 8;
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    bus_t               bus_f;
    cond_t              cond;

    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        eep_line_filter #(.SYNC_N(SYNC_N)) u_filt (
            .clk      (clk),
            .rst      (rst),
            .line_in  (raw_lines[g]),
            .line_out (filt_lines[g])
        );
    end

    assign bus_f = filt_lines;

    eep_cond_detect u_cond (
        .clk   (clk),
        .rst   (rst),
        .bus_f (bus_f),
        .cond  (cond)
    );

    eng_state_t        state;
    logic [3:0]        bitcnt;
    logic [7:0]        sh;
    logic [7:0]        tx;
    logic [ADDR_W-1:0] addr_cnt;
    logic [HI_W-1:0]   addr_hi;
    logic              rw_q;
    logic              wp_lat;
    logic              pend;

    assign rd_addr = addr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            bitcnt      <= '0;
            sh          <= '0;
            tx          <= '0;
            addr_cnt    <= '0;
            addr_hi     <= '0;
            rw_q        <= 1'b0;
            wp_lat      <= 1'b0;
            pend        <= 1'b0;
            sda_oe      <= 1'b0;
            pbuf_we     <= 1'b0;
            pbuf_addr   <= '0;
            pbuf_data   <= '0;
            commit      <= 1'b0;
            commit_page <= '0;
        end else begin
            pbuf_we <= 1'b0;
            commit  <= 1'b0;
            if (cond.start) begin
                state  <= ST_SEL;
                bitcnt <= '0;
                sda_oe <= 1'b0;
                pend   <= 1'b0;
            end else if (cond.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                pend   <= 1'b0;
                if (pend) begin
                    commit      <= 1'b1;
                    commit_page <= addr_cnt[ADDR_W-1:PAGE_W];
                end
            end else begin
                unique case (state)
                    ST_SEL, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (cond.rise && bitcnt != 4'd8) begin
                            sh     <= {sh[6:0], bus_f.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (cond.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            unique case (state)
                                ST_SEL: begin
                                    if (sel_hit(sh, dev_sel) && !wr_busy) begin
                                        rw_q   <= sh[0];
                                        sda_oe <= 1'b1;
                                        state  <= ST_SEL_ACK;
                                    end else begin
                                        state  <= ST_IDLE;
                                    end
                                end
                                ST_AHI: begin
                                    addr_hi <= sh[HI_W-1:0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_AHI_ACK;
                                end
                                ST_ALO: begin
                                    addr_cnt <= {addr_hi, sh};
                                    sda_oe   <= 1'b1;
                                    state    <= ST_ALO_ACK;
                                end
                                default: begin
                                    if (!wp_lat) begin
                                        pbuf_we   <= 1'b1;
                                        pbuf_addr <= addr_cnt;
                                        pbuf_data <= sh;
                                        addr_cnt[PAGE_W-1:0] <= addr_cnt[PAGE_W-1:0] + PAGE_W'(1);
                                        pend      <= 1'b1;
                                        sda_oe    <= 1'b1;
                                        state     <= ST_WDAT_ACK;
                                    end else begin
                                        state     <= ST_IDLE;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_SEL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK, ST_RLOAD: begin
                        if (cond.fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            if ((state == ST_SEL_ACK && rw_q) || state == ST_RLOAD) begin
                                tx       <= rd_data;
                                sda_oe   <= ~rd_data[7];
                                addr_cnt <= addr_cnt + ADDR_W'(1);
                                state    <= ST_RDAT;
                            end else if (state == ST_SEL_ACK) begin
                                state  <= ST_AHI;
                            end else if (state == ST_AHI_ACK) begin
                                state  <= ST_ALO;
                            end else if (state == ST_ALO_ACK) begin
                                wp_lat <= wp;
                                state  <= ST_WDAT;
                            end else begin
                                state  <= ST_WDAT;
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (cond.rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (cond.fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[6];
                                tx     <= tx << 1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (cond.rise) state <= bus_f.sda ? ST_IDLE : ST_RLOAD;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/eep_checker.sv
module eep_checker (
    input logic clk,
    input logic rst,
    input logic scl_f,
    input logic start_c,
    input logic stop_c,
    input logic sda_oe,
    input logic pbuf_we,
    input logic commit
);

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_f) else $error("drive changed with clock high"); // R11

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        stop_c |=> !sda_oe) else $error("line held after stop"); // R1

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        start_c |=> !sda_oe) else $error("line held after start"); // R1

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit) else $error("commit longer than one cycle"); // R5

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(stop_c)) else $error("commit without stop"); // R5

    AST_WE_COMMIT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pbuf_we, commit})) else $error("stage and commit together"); // R5

    AST_STAGE_ACKS: assert property (@(posedge clk) disable iff (rst)
        pbuf_we |-> sda_oe) else $error("staged byte without acknowledge"); // R3

endmodule

bind eeprom_serial_slave eep_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (bus_f.scl),
    .start_c (cond.start),
    .stop_c  (cond.stop),
    .sda_oe  (sda_oe),
    .pbuf_we (pbuf_we),
    .commit  (commit)
);

// File: tb/eeprom_serial_slave_bench.sv
module eeprom_serial_slave_bench;

    localparam int Q  = 12;
    localparam int WD = 180000;
    localparam logic [2:0] DEV = 3'b101;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        wp = 1'b0;
    logic        wr_busy = 1'b0;
    logic [7:0]  rd_data = 8'hFF;
    logic        sda_oe;
    logic [14:0] rd_addr;
    logic        pbuf_we;
    logic [14:0] pbuf_addr;
    logic [7:0]  pbuf_data;
    logic        commit;
    logic [8:0]  commit_page;
    logic        sda_line;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    eeprom_serial_slave u_eeprom_serial_slave (
        .clk         (clk),
        .rst         (rst),
        .scl_in      (scl_m),
        .sda_in      (sda_line),
        .dev_sel     (DEV),
        .wp          (wp),
        .wr_busy     (wr_busy),
        .rd_data     (rd_data),
        .sda_oe      (sda_oe),
        .rd_addr     (rd_addr),
        .pbuf_we     (pbuf_we),
        .pbuf_addr   (pbuf_addr),
        .pbuf_data   (pbuf_data),
        .commit      (commit),
        .commit_page (commit_page)
    );

    // ---------------- array model (external to the engine) ----------------
    logic [7:0] arr [int];
    logic [7:0] stg [int];
    int         busy_cnt = 0;
    int         commit_cnt = 0;
    int         we_cnt = 0;
    logic [8:0] last_page = '0;

    always @(posedge clk) begin
        rd_data <= arr.exists(int'(rd_addr)) ? arr[int'(rd_addr)] : 8'hFF;
        if (pbuf_we) begin
            stg[int'(pbuf_addr)] = pbuf_data;
            we_cnt++;
        end
        if (commit) begin
            foreach (stg[k]) arr[k] = stg[k];
            stg.delete();
            commit_cnt++;
            last_page = commit_page;
            busy_cnt  = 1000;
        end else if (busy_cnt > 0) begin
            busy_cnt--;
        end
        wr_busy <= (busy_cnt > 0);
    end

    // ---------------- counters and checks ----------------
    int checks = 0;
    int fails  = 0;

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // ---------------- scoreboard ----------------
    typedef struct {
        string      req;
        logic [7:0] val;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] obs_q[$];
    item_t      mon_it;
    logic [7:0] mon_got;

    task automatic push_exp(input string req, input logic [7:0] e, input logic [7:0] got);
        item_t it;
        it.req = req;
        it.val = e;
        exp_q.push_back(it);
        obs_q.push_back(got);
    endtask

    always @(negedge clk) begin
        if (obs_q.size() > 0 && exp_q.size() > 0) begin
            mon_it  = exp_q.pop_front();
            mon_got = obs_q.pop_front();
            check(mon_it.req, int'(mon_got), int'(mon_it.val));
        end
    end

    // R11 monitor: drive changes must fall in clock-low time
    logic prev_oe = 1'b0;
    int   oe_moves = 0;
    int   oe_bad = 0;
    always @(posedge clk) begin
        if (!rst && sda_oe !== prev_oe) begin
            oe_moves++;
            if (scl_m) oe_bad++;
        end
        prev_oe <= sda_oe;
    end

    // ---------------- reference memory, from the requirements ----------------
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
    endfunction

    // ---------------- bus driver ----------------
    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
        qwait();
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        sda_m = b;    qwait();
        scl_m = 1'b1; qwait();
        seen  = sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic get_byte(input logic host_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            b = {b[6:0], s};
        end
        bus_bit(~host_ack, s);
    endtask

    task automatic sel_addr(input logic [15:0] a, input string req);
        logic k;
        put_byte({4'b1010, DEV, 1'b0}, k); push_exp({req, " select ack"}, 8'd1, {7'd0, k});
        put_byte(a[15:8], k);              push_exp({req, " addr-hi ack"}, 8'd1, {7'd0, k});
        put_byte(a[7:0], k);               push_exp({req, " addr-lo ack"}, 8'd1, {7'd0, k});
    endtask

    task automatic read_run(input int a0, input int n, input string req);
        logic [7:0] b;
        logic       s;
        for (int i = 0; i < n; i++) begin
            get_byte(i < n - 1, b);
            push_exp({req, " data"}, ref_rd((a0 + i) & 32'h7FFF), b);
        end
        bus_bit(1'b1, s);
        push_exp("R9 released after host nack", 8'd1, {7'd0, s});
        bus_stop();
    endtask

    task automatic rd_at(input logic [15:0] a, input int n, input string req);
        logic k;
        bus_start();
        sel_addr(a, req);
        bus_start();
        put_byte({4'b1010, DEV, 1'b1}, k);
        push_exp({req, " read select ack"}, 8'd1, {7'd0, k});
        read_run(int'(a) & 32'h7FFF, n, req);
    endtask

    task automatic rd_now(input int a0, input int n, input string req);
        logic k;
        bus_start();
        put_byte({4'b1010, DEV, 1'b1}, k);
        push_exp({req, " read select ack"}, 8'd1, {7'd0, k});
        read_run(a0, n, req);
    endtask

    task automatic wait_ready();
        logic k;
        for (int i = 0; i < 20; i++) begin
            bus_start();
            put_byte({4'b1010, DEV, 1'b0}, k);
            bus_stop();
            if (k) break;
        end
    endtask

    task automatic wr_page(input logic [15:0] a, input logic [7:0] d [4], input int n,
                           input string req, input logic poll_check);
        logic k;
        int   base, off, c0;
        c0   = commit_cnt;
        base = int'(a) & 32'h7FC0;
        off  = int'(a) & 32'h3F;
        bus_start();
        sel_addr(a, req);
        for (int i = 0; i < n; i++) begin
            put_byte(d[i], k);
            push_exp("R3 data ack", 8'd1, {7'd0, k});
            ref_mem[base | ((off + i) & 32'h3F)] = d[i];
        end
        bus_stop();
        repeat (4) @(negedge clk);
        check("R5 one commit per stop", commit_cnt, c0 + 1);
        check("R5 commit page", int'(last_page), (int'(a) & 32'h7FFF) >> 6);
        if (poll_check) begin
            bus_start();
            put_byte({4'b1010, DEV, 1'b0}, k);
            push_exp("R6 busy select nack", 8'd0, {7'd0, k});
            bus_stop();
        end
        wait_ready();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] d [4];
        logic       k;
        logic       s;
        int         c0, w0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset line released", int'(sda_oe), 0);
        check("R5 reset no commit", int'(commit), 0);
        check("R5 reset no stage", int'(pbuf_we), 0);

        // R2: wrong strap bits are ignored
        bus_start();
        put_byte({4'b1010, 3'b011, 1'b0}, k);
        push_exp("R2 foreign select nack", 8'd0, {7'd0, k});
        bus_stop();
        // R2: wrong tag
        bus_start();
        put_byte({4'b1011, DEV, 1'b0}, k);
        push_exp("R2 wrong tag nack", 8'd0, {7'd0, k});
        bus_stop();

        // R4: bit 15 ignored -> byte lands at 0x1234; R6 polling
        d[0] = 8'hA5; d[1] = 8'h00; d[2] = 8'h00; d[3] = 8'h00;
        wr_page(16'h9234, d, 1, "R4 byte write", 1'b1);
        d[0] = 8'h5C;
        wr_page(16'h0000, d, 1, "R4 write at zero", 1'b0);

        // R10 selective read, R8 pointer one past
        rd_at(16'h1234, 1, "R10 selective read");
        rd_now(32'h1235, 1, "R8 immediate read");

        // R5 page wrap: 0x17E,0x17F,0x140,0x141
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
        wr_page(16'h017E, d, 4, "R5 page write", 1'b0);
        rd_at(16'h0140, 2, "R9 sequential after wrap");
        rd_at(16'h017E, 2, "R5 page head");

        // R8 end-of-memory roll-over
        rd_at(16'h7FFF, 2, "R8 roll-over");
        rd_now(32'h0001, 1, "R8 pointer after roll-over");

        // R7 write protect
        c0 = commit_cnt; w0 = we_cnt;
        wp = 1'b1;
        bus_start();
        sel_addr(16'h0200, "R7 protected");
        put_byte(8'h77, k);
        push_exp("R7 protected data nack", 8'd0, {7'd0, k});
        bus_stop();
        wp = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 no commit", commit_cnt, c0);
        check("R7 no stage", we_cnt, w0);
        rd_at(16'h0200, 1, "R7 memory untouched");

        // R1: stop after address only loads pointer, commits nothing
        c0 = commit_cnt;
        bus_start();
        sel_addr(16'h017F, "R1 address only");
        bus_stop();
        repeat (4) @(negedge clk);
        check("R1 no commit after address only", commit_cnt, c0);
        rd_now(32'h017F, 1, "R1 pointer kept");

        // R12: one-cycle spike while clock high inside address-hi byte
        bus_start();
        put_byte({4'b1010, DEV, 1'b0}, k);
        push_exp("R12 select ack", 8'd1, {7'd0, k});
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; @(negedge clk);
        sda_m = 1'b1; qwait();
        scl_m = 1'b0; qwait();
        for (int i = 6; i >= 0; i--) bus_bit(1'(8'h81 >> i), s);
        bus_bit(1'b1, s);
        push_exp("R12 addr-hi ack despite spike", 8'd1, {7'd0, ~s});
        put_byte(8'h7E, k);
        push_exp("R12 addr-lo ack", 8'd1, {7'd0, k});
        bus_start();
        put_byte({4'b1010, DEV, 1'b1}, k);
        push_exp("R12 read select ack", 8'd1, {7'd0, k});
        read_run(32'h017E, 1, "R12 data after spike");

        repeat (10) @(negedge clk);
        check("R11 drive changes seen", int'(oe_moves > 0), 1);
        check("R11 drive moved only with clock low", oe_bad, 0);
        check("R3 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule